// File: doc/BRIEF.md
# Measurement Cycle Sequencer for a Gated Counter

This block paces the repeating measurement cycle of a gated frequency or period counter. It watches the output of the gate flip-flop. When a gate period closes, the block sends a single-clock strobe that loads the count latches. It then holds the reading on the display for a programmable number of clock ticks. While that hold lasts, the gate enable output stays low, so the gate flip-flop cannot open a new gate period.

When the hold runs out, the block issues a two-clock clear in both polarities. The active-low form resets the gate flip-flop. The active-high form resets the timebase divider and the counting decades. After the clear, the block goes back to waiting for the next gate period, so one sample takes the gate time plus the hold time.

A front-panel reset input can force the same clear at any moment. It passes through a synchroniser and an edge detector, so a long press produces only one clear. A press during a hold cancels that hold.

Top module: `meas_cycle_seq`

## Requirements
- R1: The end of a gate period is a high-to-low change of `gate_q`, seen high at one clock edge and low at the next while the block is idle. After that second edge, `xfer_stb` is high for exactly one clock.
- R2: `hold_busy` goes high in the same cycle as `xfer_stb` and stays high for `hold_len`+1 cycles. A `hold_len` of 0 therefore gives a single-cycle hold.
- R3: `gate_en` is low whenever the block is holding or clearing. It is high only when the block is idle.
- R4: When the hold expires, `clr` is high for exactly 2 cycles, directly after the last hold cycle. The block is idle in the cycle that follows.
- R5: `clr_n` is always the inverse of `clr`.
- R6: A rising edge on `man_rst` first passes two synchroniser flops. `clr` then rises in the third cycle after the edge at which the input is first sampled high. However long the input stays high, it gives only one 2-cycle clear.
- R7: A manual reset during a hold ends the hold at once. The block runs the 2-cycle clear and then stays idle, with no further clear, until a new gate period ends.
- R8: `gate_q` activity during a hold or a clear is ignored. It gives no strobe and does not change the timing of the clear.
- R9: While `rst_n` is low and after it is released, the block is idle with `xfer_stb`=0, `hold_busy`=0, `clr`=0, `clr_n`=1 and `gate_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| gate_q | input | 1 | Output of the gate flip-flop, high during a gate period |
| hold_len | input | HOLD_W | Display-hold length in clock ticks, minus one |
| man_rst | input | 1 | Asynchronous front-panel reset request, active high |
| xfer_stb | output | 1 | Single-clock strobe that loads the count latches |
| gate_en | output | 1 | Enable for the gate flip-flop J/K inputs |
| hold_busy | output | 1 | High while the display hold is running |
| clr | output | 1 | Active-high clear for the timebase and the decades |
| clr_n | output | 1 | Active-low clear for the gate flip-flop |

## Verification
The main cycle runs many times with random hold lengths (including 0) and random gate widths and idle gaps. Each run tells whether the hold length is counted off by one and whether the strobe and the clear land on the right cycle. Some directed runs toggle `gate_q` in the middle of a hold; they show whether a second strobe or an early clear slips through. Manual presses are tried while idle, held for a long time, and during a long hold. These separate a correct single edge-triggered clear from a level-triggered one, and show whether an aborted hold later comes back to life.

// File: rtl/meas_cycle_seq.sv
module meas_cycle_seq #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_q,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              man_rst,
  output logic              xfer_stb,
  output logic              gate_en,
  output logic              hold_busy,
  output logic              clr,
  output logic              clr_n
);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_CLR} st_t;

  st_t              st;
  logic [HOLD_W-1:0] cnt;
  logic             clr_ph;
  logic             gate_d;
  logic [2:0]       msync;
  logic             man_pulse;
  logic             gate_end;

  assign man_pulse = msync[1] & ~msync[2];
  assign gate_end  = gate_d & ~gate_q & (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msync  <= '0;
      gate_d <= 1'b0;
    end else begin
      msync  <= {msync[1:0], man_rst};
      gate_d <= gate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      clr_ph   <= 1'b0;
      xfer_stb <= 1'b0;
    end else begin
      xfer_stb <= 1'b0;
      if (man_pulse) begin
        st     <= S_CLR;
        clr_ph <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (gate_end) begin
            st       <= S_HOLD;
            cnt      <= hold_len;
            xfer_stb <= 1'b1;
          end
          S_HOLD: begin
            if (cnt == '0) begin
              st     <= S_CLR;
              clr_ph <= 1'b0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_CLR: begin
            clr_ph <= 1'b1;
            if (clr_ph) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign gate_en   = (st == S_IDLE);
  assign hold_busy = (st == S_HOLD);
  assign clr       = (st == S_CLR);
  assign clr_n     = ~clr;

  a_r1_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |=> !xfer_stb);

  a_r2_xfer_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> hold_busy);

  a_r3_gate_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy || clr) |-> !gate_en);

  a_r4_clr_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) |=> clr);

  a_r4_clr_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && $past(clr) && !man_pulse) |=> !clr);

  a_r4_idle_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clr) && !man_pulse) |-> gate_en);

  a_r8_hold_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && cnt != '0 && !man_pulse) |=> hold_busy);

endmodule

// File: tb/meas_cycle_seq_tb.sv
`timescale 1ns/1ps
module meas_cycle_seq_tb;
  localparam int HW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_q = 1'b0;
  logic [HW-1:0] hold_len = '0;
  logic man_rst = 1'b0;
  logic xfer_stb, gate_en, hold_busy, clr, clr_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  meas_cycle_seq #(.HOLD_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .hold_len(hold_len),
    .man_rst(man_rst), .xfer_stb(xfer_stb), .gate_en(gate_en),
    .hold_busy(hold_busy), .clr(clr), .clr_n(clr_n));

  function automatic bit e_xfer(int k);
    return k == 1;
  endfunction
  function automatic bit e_busy(int k, int l);
    return k >= 1 && k <= l + 1;
  endfunction
  function automatic bit e_clr(int k, int l);
    return k == l + 2 || k == l + 3;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req, bit x, bit b, bit c);
    chk(req, "xfer_stb", xfer_stb, x);
    chk(req, "hold_busy", hold_busy, b);
    chk(req, "clr", clr, c);
    chk("R5", "clr_n", clr_n, ~c);
    chk("R3", "gate_en", gate_en, ~(b | c));
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk("R1", "idle", xfer_stb | hold_busy | clr, 1'b0);
    end
  endtask

  task automatic gate_run(int l, int gh, bit inject);
    @(negedge clk);
    hold_len = HW'(l);
    gate_q = 1'b1;
    for (int i = 0; i < gh; i++) begin
      @(posedge clk); #1;
      chk("R1", "no strobe during gate", xfer_stb, 1'b0);
      @(negedge clk);
    end
    gate_q = 1'b0;
    for (int k = 1; k <= l + 5; k++) begin
      @(posedge clk); #1;
      if (inject) chk_all("R8", e_xfer(k), e_busy(k, l), e_clr(k, l));
      else if (l == 0) chk_all("R2", e_xfer(k), e_busy(k, l), e_clr(k, l));
      else chk_all("R4", e_xfer(k), e_busy(k, l), e_clr(k, l));
      if (inject && k == 2) gate_q = 1'b1;
      if (inject && k == 3) gate_q = 1'b0;
      if (inject && k == l + 2) gate_q = 1'b1;
      if (inject && k == l + 3) gate_q = 1'b0;
    end
  endtask

  task automatic press(int len);
    @(negedge clk);
    man_rst = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); #1;
      chk("R6", "manual", clr, k == 3 || k == 4);
      chk("R5", "clr_n manual", clr_n, !(k == 3 || k == 4));
      chk("R6", "gate_en manual", gate_en, !(k == 3 || k == 4));
    end
    @(negedge clk);
    man_rst = 1'b0;
    idle_cycles(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1;
    chk_all("R9", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(3);
    chk("R9", "gate_en after reset", gate_en, 1'b1);

    gate_run(0, 3, 1'b0);
    idle_cycles(2);
    gate_run(5, 1, 1'b0);
    idle_cycles(2);
    gate_run(6, 4, 1'b1);
    idle_cycles(2);

    for (int it = 0; it < 25; it++) begin
      int l, gh, gap;
      l = int'($urandom_range(0, 12));
      gh = int'($urandom_range(1, 10));
      gap = int'($urandom_range(1, 5));
      gate_run(l, gh, (l >= 4) && ($urandom_range(0, 1) == 1));
      idle_cycles(gap);
    end

    press(6);
    press(40);

    @(negedge clk);
    hold_len = HW'(30);
    gate_q = 1'b1;
    @(negedge clk);
    gate_q = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #1;
      chk("R7", "busy before abort", hold_busy, 1'b1);
    end
    man_rst = 1'b1;
    for (int k = 1; k <= 36; k++) begin
      @(posedge clk); #1;
      chk("R7", "clr after abort", clr, k == 3 || k == 4);
      chk("R7", "busy after abort", hold_busy, k < 3);
      chk("R7", "no strobe", xfer_stb, 1'b0);
      if (k == 10) man_rst = 1'b0;
    end
    gate_run(2, 2, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule